// File: doc/BRIEF.md
# Two-dimensional block DMA engine

This engine moves a rectangle of data elements from one memory space to another for a display subsystem. Software describes the rectangle with six plain inputs: width and height (each written as count minus one), and the start coordinates of source and destination. It then writes an 8-bit control register whose go bit launches the transfer. Each coordinate pair maps to a linear address of the form y * 2^XW + x, and a coordinate that steps past either edge wraps around.

The source walk direction can be reversed on each axis on its own. The destination always steps forward in x and, at the end of each row, forward in y. A 2-bit path field picks the memory pair. A mode bit picks between a straight overwrite and a compound merge. In a compound merge the destination is read first and then written with the OR of its old value and the source value.

Memories sit outside the block, behind generic request ports that return read data one cycle after the request. The go bit clears itself when the last element has been written, and a one-cycle done pulse follows.

Top module: `blkdma_top`

## Requirements
- R1: While reset is asserted and after it is released, cfgQ reads 0, busy and done are low, and no read or write request is raised.
- R2: The control register is written in cycle 0 with go (bit 0) set. The first source read is issued in cycle 2. Each element then takes two cycles: a read cycle (srcRdEn) and a write cycle (dstWrEn). Elements are processed row by row, and from left to right within a row.
- R3: Control bit 1 selects the source x step per element: 0 adds one and 1 subtracts one, modulo 2^XW. At the end of each row the source x returns to its start value.
- R4: Control bit 2 selects the source y step per row: 0 adds one and 1 subtracts one, modulo 2^YW.
- R5: The destination starts at (dstX0, dstY0). Its x steps up by one per element, returns to dstX0 at the end of each row, and its y then steps up by one. The address is {y, x}.
- R6: Control bits 4:3 select the path, with spaces coded 0 video RAM, 1 ROM, 2 extended RAM. 00 reads space 0 and writes space 0. 01 reads space 1 and writes space 0. 10 reads space 2 and writes space 0. 11 reads space 0 and writes space 2.
- R7: With control bit 5 set (overwrite), each destination element is written with the source value, and no destination read is issued.
- R8: With control bit 5 clear (compound), the destination element is read in the same cycle as the source element. In the next cycle it is written, at the same address, with the bitwise OR of the two values.
- R9: A transfer of N elements that is not interrupted ends in cycle 2N+2. In that cycle done is high for one cycle, busy is low and the go bit reads 0.
- R10: Writing go = 0 during a read cycle lets that element's write happen in the next cycle and then stops. Writing go = 0 during a write cycle lets that write finish and issues nothing more. In both cases done stays low.
- R11: No write request is ever raised with dstSpace equal to 1 (ROM).
- R12: A control write that lands in the last element's write cycle takes priority over the self-clear. If that write sets go, a new transfer issues its first read two cycles later, and done still pulses for the finished transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWe | input | 1 | Control register write strobe |
| cfgWdata | input | 8 | Control write data: go, x-reverse, y-reverse, path[1:0], overwrite in bits 0 to 5 |
| cfgQ | output | 8 | Control register read-back (bits 7:6 read 0) |
| blkWM1 | input | XW | Block width minus one |
| blkHM1 | input | YW | Block height minus one |
| srcX0 | input | XW | Source start x |
| srcY0 | input | YW | Source start y |
| dstX0 | input | XW | Destination start x |
| dstY0 | input | YW | Destination start y |
| srcRdEn | output | 1 | Source read request |
| srcSpace | output | 2 | Source memory space |
| srcAddr | output | XW+YW | Source address |
| srcRdata | input | DW | Source read data, one cycle after the request |
| dstRdEn | output | 1 | Destination read request (compound mode) |
| dstWrEn | output | 1 | Destination write request |
| dstSpace | output | 2 | Destination memory space |
| dstAddr | output | XW+YW | Destination address |
| dstRdata | input | DW | Destination read data, one cycle after the request |
| dstWdata | output | DW | Destination write data |
| busy | output | 1 | Engine is not idle |
| done | output | 1 | One-cycle pulse after the last element is written |

## Verification
Two events can land in the same cycle: a software write to the control register, and the engine's own clearing of the go bit after the final element. The bench provokes this by writing go = 1 exactly in the write cycle of a single-element transfer. It then checks three things: done still pulses, the go bit reads 1 instead of 0, and a fresh source read appears two cycles later. A second overlap is an abort arriving while an element is halfway done. It is placed once in a read cycle and once in a write cycle, and the bench counts how many writes reach memory after each.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  localparam int CFG_W    = 8;
  localparam int CFG_USED = 6;
  localparam int GO_BIT   = 0;
  localparam int XREV_BIT = 1;
  localparam int YREV_BIT = 2;
  localparam int PATH_LO  = 3;
  localparam int OVR_BIT  = 5;

  typedef enum logic [1:0] {
    SP_VRAM = 2'd0,
    SP_ROM  = 2'd1,
    SP_XRAM = 2'd2
  } space_e;

  typedef enum logic [1:0] {
    PATH_V2V = 2'd0,
    PATH_R2V = 2'd1,
    PATH_X2V = 2'd2,
    PATH_V2X = 2'd3
  } path_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // snapshot config and coordinates
    logic step;     // advance to the next element
    logic rdPhase;  // element read cycle
    logic wrPhase;  // element write cycle
  } strobe_t;

  function automatic space_e srcSpaceOf(input path_e p);
    case (p)
      PATH_R2V: return SP_ROM;
      PATH_X2V: return SP_XRAM;
      default:  return SP_VRAM;
    endcase
  endfunction

  function automatic space_e dstSpaceOf(input path_e p);
    if (p == PATH_V2X) return SP_XRAM;
    return SP_VRAM;
  endfunction

endpackage

// File: rtl/blkdma_coord.sv
module blkdma_coord #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] startVal,
  input  logic         adv,
  input  logic         rewind,
  input  logic         dec,
  output logic [W-1:0] pos
);

  logic [W-1:0] base;
  logic [W-1:0] stepped;

  assign stepped = dec ? pos - W'(1) : pos + W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos  <= '0;
      base <= '0;
    end else if (load) begin
      pos  <= startVal;
      base <= startVal;
    end else if (rewind) begin
      pos  <= base;
    end else if (adv) begin
      pos  <= stepped;
    end
  end

endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
  import blkdma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  input  logic             lastElem,
  output logic [CFG_W-1:0] cfgQ,
  output strobe_t          strb,
  output logic             busy,
  output logic             done
);

  logic [CFG_USED-1:0] cfgReg;
  state_e              state, stateNx;
  logic                finish;
  logic                go;

  assign go   = cfgReg[GO_BIT];
  assign cfgQ = {{(CFG_W-CFG_USED){1'b0}}, cfgReg};
  assign busy = (state != ST_IDLE);

  always_comb begin
    stateNx = state;
    strb    = '0;
    finish  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (go) begin
          strb.load = 1'b1;
          stateNx   = ST_RD;
        end
      end
      ST_RD: begin
        if (!go) begin
          stateNx = ST_IDLE;
        end else begin
          strb.rdPhase = 1'b1;
          stateNx      = ST_WR;
        end
      end
      ST_WR: begin
        strb.wrPhase = 1'b1;
        strb.step    = 1'b1;
        if (lastElem) begin
          finish  = 1'b1;
          stateNx = ST_IDLE;
        end else if (!go) begin
          stateNx = ST_IDLE;
        end else begin
          stateNx = ST_RD;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cfgReg <= '0;
      done   <= 1'b0;
    end else begin
      state <= stateNx;
      done  <= finish && go;
      if (cfgWe) begin
        cfgReg <= cfgWdata[CFG_USED-1:0];
      end else if (finish) begin
        cfgReg[GO_BIT] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/blkdma_dpath.sv
module blkdma_dpath
  import blkdma_pkg::*;
#(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic [CFG_USED-1:0] cfgSnap,
  input  logic [XW-1:0]       blkWM1,
  input  logic [YW-1:0]       blkHM1,
  input  logic [XW-1:0]       srcX0,
  input  logic [YW-1:0]       srcY0,
  input  logic [XW-1:0]       dstX0,
  input  logic [YW-1:0]       dstY0,
  input  logic [DW-1:0]       srcRdata,
  input  logic [DW-1:0]       dstRdata,
  output logic                lastElem,
  output logic                ovrMode,
  output logic [1:0]          srcSpace,
  output logic [1:0]          dstSpace,
  output logic [XW+YW-1:0]    srcAddr,
  output logic [XW+YW-1:0]    dstAddr,
  output logic [DW-1:0]       dstWdata
);

  localparam int NAX = 4;  // source x, source y, destination x, destination y

  logic [XW-1:0] xCnt, wLat;
  logic [YW-1:0] yCnt, hLat;
  logic          xRev, yRev;
  path_e         pathLat;
  logic          rowEnd;

  assign rowEnd   = (xCnt == wLat);
  assign lastElem = rowEnd && (yCnt == hLat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCnt    <= '0;
      yCnt    <= '0;
      wLat    <= '0;
      hLat    <= '0;
      xRev    <= 1'b0;
      yRev    <= 1'b0;
      pathLat <= PATH_V2V;
      ovrMode <= 1'b0;
    end else if (strb.load) begin
      xCnt    <= '0;
      yCnt    <= '0;
      wLat    <= blkWM1;
      hLat    <= blkHM1;
      xRev    <= cfgSnap[XREV_BIT];
      yRev    <= cfgSnap[YREV_BIT];
      pathLat <= path_e'(cfgSnap[PATH_LO+1:PATH_LO]);
      ovrMode <= cfgSnap[OVR_BIT];
    end else if (strb.step) begin
      if (rowEnd) begin
        xCnt <= '0;
        yCnt <= yCnt + YW'(1);
      end else begin
        xCnt <= xCnt + XW'(1);
      end
    end
  end

  // per-axis control: x axes advance per element and rewind at row end,
  // y axes advance only at row end
  logic [NAX-1:0] axAdv, axRew, axDec;
  logic [XW-1:0]  sxPos, dxPos;
  logic [YW-1:0]  syPos, dyPos;

  generate
    for (genvar a = 0; a < NAX; a++) begin : g_axis
      localparam bit IS_X   = (a % 2) == 0;
      localparam bit IS_SRC = a < 2;
      if (IS_X) begin : g_x
        assign axAdv[a] = strb.step && !rowEnd;
        assign axRew[a] = strb.step && rowEnd;
        assign axDec[a] = IS_SRC ? xRev : 1'b0;
        logic [XW-1:0] posX;
        blkdma_coord #(.W(XW)) coord_i (
          .clk      (clk),
          .rstN     (rstN),
          .load     (strb.load),
          .startVal (IS_SRC ? srcX0 : dstX0),
          .adv      (axAdv[a]),
          .rewind   (axRew[a]),
          .dec      (axDec[a]),
          .pos      (posX)
        );
        if (IS_SRC) begin : g_s
          assign sxPos = posX;
        end else begin : g_d
          assign dxPos = posX;
        end
      end else begin : g_y
        assign axAdv[a] = strb.step && rowEnd;
        assign axRew[a] = 1'b0;
        assign axDec[a] = IS_SRC ? yRev : 1'b0;
        logic [YW-1:0] posY;
        blkdma_coord #(.W(YW)) coord_i (
          .clk      (clk),
          .rstN     (rstN),
          .load     (strb.load),
          .startVal (IS_SRC ? srcY0 : dstY0),
          .adv      (axAdv[a]),
          .rewind   (axRew[a]),
          .dec      (axDec[a]),
          .pos      (posY)
        );
        if (IS_SRC) begin : g_s
          assign syPos = posY;
        end else begin : g_d
          assign dyPos = posY;
        end
      end
    end
  endgenerate

  assign srcAddr  = {syPos, sxPos};
  assign dstAddr  = {dyPos, dxPos};
  assign srcSpace = srcSpaceOf(pathLat);
  assign dstSpace = dstSpaceOf(pathLat);
  assign dstWdata = ovrMode ? srcRdata : (srcRdata | dstRdata);

endmodule

// File: rtl/blkdma_top.sv
module blkdma_top
  import blkdma_pkg::*;
#(
  parameter int XW = 4,
  parameter int YW = 4,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [7:0]       cfgWdata,
  output logic [7:0]       cfgQ,
  input  logic [XW-1:0]    blkWM1,
  input  logic [YW-1:0]    blkHM1,
  input  logic [XW-1:0]    srcX0,
  input  logic [YW-1:0]    srcY0,
  input  logic [XW-1:0]    dstX0,
  input  logic [YW-1:0]    dstY0,
  output logic             srcRdEn,
  output logic [1:0]       srcSpace,
  output logic [XW+YW-1:0] srcAddr,
  input  logic [DW-1:0]    srcRdata,
  output logic             dstRdEn,
  output logic             dstWrEn,
  output logic [1:0]       dstSpace,
  output logic [XW+YW-1:0] dstAddr,
  input  logic [DW-1:0]    dstRdata,
  output logic [DW-1:0]    dstWdata,
  output logic             busy,
  output logic             done
);

  strobe_t strb;
  logic    lastElem;
  logic    ovrMode;

  blkdma_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .lastElem (lastElem),
    .cfgQ     (cfgQ),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  blkdma_dpath #(.XW(XW), .YW(YW), .DW(DW)) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgSnap  (cfgQ[CFG_USED-1:0]),
    .blkWM1   (blkWM1),
    .blkHM1   (blkHM1),
    .srcX0    (srcX0),
    .srcY0    (srcY0),
    .dstX0    (dstX0),
    .dstY0    (dstY0),
    .srcRdata (srcRdata),
    .dstRdata (dstRdata),
    .lastElem (lastElem),
    .ovrMode  (ovrMode),
    .srcSpace (srcSpace),
    .dstSpace (dstSpace),
    .srcAddr  (srcAddr),
    .dstAddr  (dstAddr),
    .dstWdata (dstWdata)
  );

  assign srcRdEn = strb.rdPhase;
  assign dstRdEn = strb.rdPhase && !ovrMode;
  assign dstWrEn = strb.wrPhase;

endmodule

// File: rtl/blkdma_chk.sv
module blkdma_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          srcRdEn,
  input logic          dstRdEn,
  input logic          dstWrEn,
  input logic [1:0]    dstSpace,
  input logic [AW-1:0] dstAddr,
  input logic          busy,
  input logic          done
);

  // R11: ROM space is never a write target
  p_rom_never_written_r11: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> dstSpace != 2'd1);

  // R2: every read cycle is followed by a write cycle
  p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    srcRdEn |=> dstWrEn);

  // R2: a write is always preceded by its source read
  p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    dstWrEn |-> $past(srcRdEn));

  // R8: destination read pairs with the source read and a same-address write
  p_dst_read_pairs_r8: assert property (@(posedge clk) disable iff (!rstN)
    dstRdEn |-> srcRdEn);
  p_rmw_same_addr_r8: assert property (@(posedge clk) disable iff (!rstN)
    dstRdEn |=> (dstWrEn && $stable(dstAddr)));

  // R9: done is a single-cycle pulse, seen only once the engine is idle
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R1: an idle engine raises no request
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!srcRdEn && !dstRdEn && !dstWrEn));

endmodule

bind blkdma_top blkdma_chk #(.AW(XW+YW)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .srcRdEn  (srcRdEn),
  .dstRdEn  (dstRdEn),
  .dstWrEn  (dstWrEn),
  .dstSpace (dstSpace),
  .dstAddr  (dstAddr),
  .busy     (busy),
  .done     (done)
);

// File: tb/blkdma_top_tb_top.sv
module blkdma_top_tb_top;

  localparam int XW = 4;
  localparam int YW = 4;
  localparam int DW = 8;
  localparam int NX = 1 << XW;
  localparam int NY = 1 << YW;
  localparam int MEMD = NX * NY;
  localparam int NVEC = 8;

  // {cfg[7:0], wM1[3:0], hM1[3:0], sx, sy, dx, dy}
  // cfg: bit0 go, bit1 x reverse, bit2 y reverse, bits4:3 path, bit5 overwrite
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h21, 4'd3,  4'd2, 4'd1,  4'd2,  4'd8,  4'd9 },  // V->V overwrite
    {8'h2B, 4'd4,  4'd1, 4'd6,  4'd0,  4'd0,  4'd12},  // ROM->V overwrite, x reverse
    {8'h15, 4'd2,  4'd3, 4'd3,  4'd10, 4'd5,  4'd0 },  // X->V compound, y reverse
    {8'h3F, 4'd5,  4'd2, 4'd4,  4'd1,  4'd14, 4'd15},  // V->X overwrite, both reverse, wraps
    {8'h03, 4'd1,  4'd1, 4'd0,  4'd5,  4'd3,  4'd5 },  // V->V compound, x wraps down
    {8'h19, 4'd7,  4'd0, 4'd0,  4'd0,  4'd0,  4'd0 },  // V->X compound
    {8'h0D, 4'd0,  4'd0, 4'd9,  4'd9,  4'd9,  4'd9 },  // ROM->V compound, single element
    {8'h31, 4'd15, 4'd0, 4'd2,  4'd3,  4'd2,  4'd4 }   // X->V overwrite, full row
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgWe = 1'b0;
  logic [7:0]       cfgWdata = '0;
  logic [7:0]       cfgQ;
  logic [XW-1:0]    blkWM1 = '0;
  logic [YW-1:0]    blkHM1 = '0;
  logic [XW-1:0]    srcX0 = '0;
  logic [YW-1:0]    srcY0 = '0;
  logic [XW-1:0]    dstX0 = '0;
  logic [YW-1:0]    dstY0 = '0;
  logic             srcRdEn, dstRdEn, dstWrEn, busy, done;
  logic [1:0]       srcSpace, dstSpace;
  logic [XW+YW-1:0] srcAddr, dstAddr;
  logic [DW-1:0]    srcRdata = '0;
  logic [DW-1:0]    dstRdata = '0;
  logic [DW-1:0]    dstWdata;

  always #5 clk = ~clk;

  blkdma_top #(.XW(XW), .YW(YW), .DW(DW)) dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgQ(cfgQ),
    .blkWM1(blkWM1), .blkHM1(blkHM1), .srcX0(srcX0), .srcY0(srcY0),
    .dstX0(dstX0), .dstY0(dstY0), .srcRdEn(srcRdEn), .srcSpace(srcSpace),
    .srcAddr(srcAddr), .srcRdata(srcRdata), .dstRdEn(dstRdEn), .dstWrEn(dstWrEn),
    .dstSpace(dstSpace), .dstAddr(dstAddr), .dstRdata(dstRdata),
    .dstWdata(dstWdata), .busy(busy), .done(done)
  );

  // memory spaces: 0 video RAM, 1 ROM, 2 extended RAM
  logic [DW-1:0] mem   [0:2][0:MEMD-1];
  logic [DW-1:0] refm  [0:2][0:MEMD-1];
  int wrCnt = 0, rdCnt = 0, romWr = 0, doneCnt = 0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    if (srcRdEn && srcSpace < 2'd3) srcRdata <= mem[srcSpace][srcAddr];
    if (dstRdEn && dstSpace < 2'd3) dstRdata <= mem[dstSpace][dstAddr];
    if (dstWrEn && dstSpace < 2'd3) mem[dstSpace][dstAddr] <= dstWdata;
    if (rstN) begin
      if (dstWrEn) wrCnt <= wrCnt + 1;
      if (dstRdEn) rdCnt <= rdCnt + 1;
      if (dstWrEn && dstSpace == 2'd1) romWr <= romWr + 1;
      if (done) doneCnt <= doneCnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic initMem(input int seed);
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < MEMD; a++) begin
        mem[s][a]  = DW'(((a ^ (s << 5)) * 29 + seed * 11) >> 1);
        if ((a + seed) % 5 == 0) mem[s][a] = '0;
        refm[s][a] = mem[s][a];
      end
  endtask

  task automatic model(input logic [31:0] v);
    logic [7:0] c;
    int w, h, sx, sy, dx, dy, ss, ds, sxc, syc, sa, da;
    logic [DW-1:0] sv, dv;
    c = v[31:24]; w = v[23:20]; h = v[19:16];
    sx = v[15:12]; sy = v[11:8]; dx = v[7:4]; dy = v[3:0];
    case (c[4:3]) 2'd1: ss = 1; 2'd2: ss = 2; default: ss = 0; endcase
    ds = (c[4:3] == 2'd3) ? 2 : 0;
    for (int r = 0; r <= h; r++)
      for (int k = 0; k <= w; k++) begin
        sxc = c[1] ? (sx - k) & (NX-1) : (sx + k) & (NX-1);
        syc = c[2] ? (sy - r) & (NY-1) : (sy + r) & (NY-1);
        sa = syc * NX + sxc;
        da = ((dy + r) & (NY-1)) * NX + ((dx + k) & (NX-1));
        sv = refm[ss][sa];
        dv = refm[ds][da];
        refm[ds][da] = c[5] ? sv : (sv | dv);
      end
  endtask

  task automatic compareMem(input string req);
    int bad = 0, fs = 0, fa = 0;
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < MEMD; a++)
        if (mem[s][a] !== refm[s][a]) begin
          if (bad == 0) begin fs = s; fa = a; end
          bad++;
        end
    check(bad == 0, req, int'(mem[fs][fa]), int'(refm[fs][fa]));
    if (bad != 0) $display("  first mismatch space %0d addr %0d, %0d bad", fs, fa, bad);
  endtask

  task automatic setGeom(input logic [31:0] v);
    blkWM1 = v[23:20]; blkHM1 = v[19:16];
    srcX0 = v[15:12]; srcY0 = v[11:8]; dstX0 = v[7:4]; dstY0 = v[3:0];
  endtask

  task automatic runVec(input logic [31:0] v, input int seed);
    int n, nEl, wr0, rd0, rom0;
    initMem(seed);
    model(v);
    setGeom(v);
    nEl = (int'(v[23:20]) + 1) * (int'(v[19:16]) + 1);
    wr0 = wrCnt; rd0 = rdCnt; rom0 = romWr;
    @(negedge clk); cfgWe = 1'b1; cfgWdata = v[31:24];
    @(negedge clk); cfgWe = 1'b0; n = 1;
    while (!done && n < 600) begin @(negedge clk); n++; end
    check(n == 2 * nEl + 2, "R2/R9 cycles to done", n, 2 * nEl + 2);
    check(!busy && cfgQ[0] == 1'b0, "R9 go self-clear", int'(cfgQ), int'(v[31:24] & 8'h3E));
    check(wrCnt - wr0 == nEl, "R2 write count", wrCnt - wr0, nEl);
    check(rdCnt - rd0 == (v[29] ? 0 : nEl), "R7/R8 destination reads",
          rdCnt - rd0, v[29] ? 0 : nEl);
    check(romWr == rom0, "R11 ROM writes", romWr - rom0, 0);
    compareMem("R3/R4/R5/R6/R7/R8 memory contents");
    @(negedge clk);
    check(!done, "R9 done width", int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int w0, d0;
    initMem(0);
    // R1: reset state
    repeat (3) @(negedge clk);
    check(cfgQ == 8'h00 && !busy && !done, "R1 state in reset", int'(cfgQ), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!srcRdEn && !dstRdEn && !dstWrEn && !busy && cfgQ == 8'h00,
          "R1 after reset", int'({srcRdEn, dstRdEn, dstWrEn, busy}), 0);

    // table-driven transfers
    for (int i = 0; i < NVEC; i++) runVec(VEC[i], i + 1);

    // R2: first read in cycle 2
    initMem(20); setGeom({8'h21, 4'd1, 4'd0, 4'd0, 4'd0, 4'd0, 4'd1});
    @(negedge clk); cfgWe = 1'b1; cfgWdata = 8'h21;
    @(negedge clk); cfgWe = 1'b0;
    check(!srcRdEn, "R2 no read in cycle 1", int'(srcRdEn), 0);
    @(negedge clk);
    check(srcRdEn && srcSpace == 2'd0 && srcAddr == 8'h00, "R2 read in cycle 2",
          int'(srcAddr), 0);
    @(negedge clk);
    check(dstWrEn && dstAddr == 8'h10, "R2/R5 write in cycle 3", int'(dstAddr), 16);
    repeat (4) @(negedge clk);

    // R10: abort during a read cycle
    setGeom({8'h21, 4'd3, 4'd3, 4'd0, 4'd0, 4'd0, 4'd8});
    w0 = wrCnt; d0 = doneCnt;
    @(negedge clk); cfgWe = 1'b1; cfgWdata = 8'h21;        // cycle 0
    @(negedge clk); cfgWe = 1'b0;                          // cycle 1
    repeat (3) @(negedge clk);                             // cycle 4: read
    check(srcRdEn, "R10 in read cycle before abort", int'(srcRdEn), 1);
    cfgWe = 1'b1; cfgWdata = 8'h20;
    @(negedge clk); cfgWe = 1'b0;                          // cycle 5
    check(dstWrEn, "R10 pending write completes", int'(dstWrEn), 1);
    @(negedge clk);                                        // cycle 6
    check(!busy && !srcRdEn && !dstWrEn, "R10 stopped after read abort",
          int'({busy, srcRdEn, dstWrEn}), 0);
    repeat (5) @(negedge clk);
    check(wrCnt - w0 == 2 && doneCnt == d0, "R10 writes after read abort", wrCnt - w0, 2);

    // R10: abort during a write cycle
    w0 = wrCnt; d0 = doneCnt;
    @(negedge clk); cfgWe = 1'b1; cfgWdata = 8'h21;        // cycle 0
    @(negedge clk); cfgWe = 1'b0;                          // cycle 1
    repeat (4) @(negedge clk);                             // cycle 5: write
    check(dstWrEn, "R10 in write cycle before abort", int'(dstWrEn), 1);
    cfgWe = 1'b1; cfgWdata = 8'h20;
    @(negedge clk); cfgWe = 1'b0;                          // cycle 6
    check(!srcRdEn && !dstWrEn && !dstRdEn, "R10 no request after write abort",
          int'({srcRdEn, dstWrEn, dstRdEn}), 0);
    @(negedge clk);
    check(!busy, "R10 idle after write abort", int'(busy), 0);
    repeat (4) @(negedge clk);
    check(wrCnt - w0 == 2 && doneCnt == d0, "R10 writes after write abort", wrCnt - w0, 2);

    // R12: control write collides with completion
    setGeom({8'h21, 4'd0, 4'd0, 4'd2, 4'd2, 4'd3, 4'd3});
    @(negedge clk); cfgWe = 1'b1; cfgWdata = 8'h21;        // cycle 0
    @(negedge clk); cfgWe = 1'b0;                          // cycle 1
    @(negedge clk);                                        // cycle 2
    @(negedge clk);                                        // cycle 3: last write
    check(dstWrEn, "R12 final write cycle", int'(dstWrEn), 1);
    cfgWe = 1'b1; cfgWdata = 8'h21;
    @(negedge clk); cfgWe = 1'b0;                          // cycle 4
    check(done, "R9/R12 done still pulses", int'(done), 1);
    check(cfgQ == 8'h21, "R12 software write wins", int'(cfgQ), 33);
    @(negedge clk);                                        // cycle 5
    check(srcRdEn, "R12 restart read", int'(srcRdEn), 1);
    @(negedge clk);                                        // cycle 6
    @(negedge clk);                                        // cycle 7
    check(done && cfgQ[0] == 1'b0, "R12 restarted transfer ends", int'(done), 1);
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule